// File: doc/BRIEF.md
# DDR Clock-Enable Power-Down Controller

This block sits next to a DDR SDRAM command scheduler and owns the clock-enable pin. It watches two pending-work flags, one for accesses and one for refreshes. When dynamic power-down is enabled and both flags stay clear, it lowers CKE. When work appears again it raises CKE and holds the scheduler off for a programmable exit delay. The exit delay depends on the kind of power-down. If any bank was open when CKE fell, the active-power-down count applies. If every bank was precharged, the precharge-power-down count applies.

A sleep request takes the memory into a long low-power period. When self-refresh is enabled, the device refreshes itself during sleep and a separate 8-bit count sets the wake-up delay. When self-refresh is disabled, CKE simply stays low with no refresh until sleep ends. While CKE is low and throughout any exit delay, the command bus carries NOP. The ready output tells the scheduler when it may issue commands again.

Top module: `cke_pd_ctrl`

## Requirements
- R1: After reset, cke_o=1, nop_o=0 and ready_o=1.
- R2: With dyn_pd_en_i=1, suppose acc_pend_i=0 and ref_pend_i=0 at two consecutive clock edges. After the first edge cke_o stays 1 and ready_o stays 1. After the second edge cke_o=0, nop_o=1 and ready_o=0.
- R3: Suppose an access or refresh becomes pending, or dyn_pd_en_i is cleared, at the second of those edges. Then power-down entry is cancelled and cke_o and ready_o stay 1.
- R4: During dynamic power-down, a pending access, a pending refresh, or dyn_pd_en_i=0 raises cke_o at the next edge. At that point nop_o=1 and ready_o=0.
- R5: The exit phase lasts N cycles with cke_o=1 and ready_o=0, after which ready_o=1. N is act_exit_i if bank_open_i was 1 at the edge where cke_o fell, otherwise pre_exit_i. A count of 0 acts as 1, so at least one cycle always separates the rise of CKE from ready.
- R6: With dyn_pd_en_i=0 and no sleep request, cke_o stays 1 however long the block is idle.
- R7: With sr_en_i=1, sleep_req_i=1 and acc_pend_i=0 at an edge, the block enters self-refresh. cke_o drops at that edge. A pending access blocks entry, and pending work does not wake the block from self-refresh.
- R8: When sleep_req_i falls, the block leaves self-refresh. ready_o then stays 0 for sr_exit_i cycles, with 0 acting as 1.
- R9: With sr_en_i=0, a sleep request lowers cke_o with no refresh. Pending accesses and refreshes are then ignored until sleep_req_i falls, and the exit uses the power-down count chosen as in R5.
- R10: nop_o=1 whenever cke_o=0 or ready_o=0. nop_o=0 whenever ready_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dyn_pd_en_i | input | 1 | Enable for dynamic power-down |
| sr_en_i | input | 1 | Enable for self-refresh during sleep |
| sleep_req_i | input | 1 | Sleep request, held for the whole sleep period |
| acc_pend_i | input | 1 | A memory access is scheduled |
| ref_pend_i | input | 1 | A refresh is scheduled |
| bank_open_i | input | 1 | At least one bank is open |
| act_exit_i | input | 4 | Exit cycles after active power-down |
| pre_exit_i | input | 4 | Exit cycles after precharge power-down |
| sr_exit_i | input | 8 | Exit cycles after self-refresh |
| cke_o | output | 1 | Clock enable to the SDRAM |
| nop_o | output | 1 | Force NOP on the command bus |
| ready_o | output | 1 | Scheduler may issue commands |

## Verification
Some properties are checked by assertions on every cycle:
- CKE low always comes with NOP and ready low.
- A rising CKE never coincides with ready.
- CKE falls only after the access flag was clear.
- Self-refresh is entered only when its enable was set.
- The exit counter is never loaded with zero.

Other behaviour only the bench scenarios can show. This covers the exact exit length for each count source, including the bank state sampled at entry and the zero-count floor. It also covers the one-cycle cancellation window, and that pending work is ignored during both kinds of sleep.

// File: rtl/cke_pd_pkg.sv
package cke_pd_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE,
    ST_PD_ENTER,
    ST_PD,
    ST_PD_EXIT,
    ST_SR,
    ST_SR_EXIT
  } pd_state_e;
endpackage

// File: rtl/cke_pd_exit_sel.sv
module cke_pd_exit_sel #(
  parameter int PD_W  = 4,
  parameter int SR_W  = 8,
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             capture_i,
  input  logic             bank_open_i,
  input  logic             sel_sr_i,
  input  logic [PD_W-1:0]  act_exit_i,
  input  logic [PD_W-1:0]  pre_exit_i,
  input  logic [SR_W-1:0]  sr_exit_i,
  output logic [CNT_W-1:0] val_o
);
  logic             active_pd_q;
  logic [CNT_W-1:0] act_ext, pre_ext, sr_ext;

  assign act_ext = CNT_W'(act_exit_i);
  assign pre_ext = CNT_W'(pre_exit_i);
  assign sr_ext  = CNT_W'(sr_exit_i);

  // power-down kind is fixed at the edge CKE falls
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        active_pd_q <= 1'b0;
    else if (capture_i) active_pd_q <= bank_open_i;
  end

  always_comb begin
    if (sel_sr_i)         val_o = sr_ext;
    else if (active_pd_q) val_o = act_ext;
    else                  val_o = pre_ext;
  end
endmodule

// File: rtl/cke_pd_exit_timer.sv
module cke_pd_exit_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= (val_i == '0) ? CNT_W'(1) : val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last_o = (cnt_q == CNT_W'(1));

  a_r5_load_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q != '0));
endmodule

// File: rtl/cke_pd_ctrl.sv
module cke_pd_ctrl
  import cke_pd_pkg::*;
#(
  parameter int PD_W = 4,
  parameter int SR_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dyn_pd_en_i,
  input  logic            sr_en_i,
  input  logic            sleep_req_i,
  input  logic            acc_pend_i,
  input  logic            ref_pend_i,
  input  logic            bank_open_i,
  input  logic [PD_W-1:0] act_exit_i,
  input  logic [PD_W-1:0] pre_exit_i,
  input  logic [SR_W-1:0] sr_exit_i,
  output logic            cke_o,
  output logic            nop_o,
  output logic            ready_o
);
  localparam int CNT_W = (SR_W > PD_W) ? SR_W : PD_W;

  pd_state_e        state_q, state_d;
  logic             sleep_mode_q, sleep_mode_d;
  logic             idle, wake, load, last;
  logic [CNT_W-1:0] exit_val;

  assign idle = !acc_pend_i && !ref_pend_i;
  assign wake = sleep_mode_q ? !sleep_req_i : (!dyn_pd_en_i || !idle);

  always_comb begin
    state_d      = state_q;
    sleep_mode_d = sleep_mode_q;
    unique case (state_q)
      ST_ACTIVE: begin
        if (sleep_req_i && !acc_pend_i) begin
          state_d      = sr_en_i ? ST_SR : ST_PD;
          sleep_mode_d = 1'b1;
        end else if (dyn_pd_en_i && idle) begin
          state_d = ST_PD_ENTER;
        end
      end
      ST_PD_ENTER: begin
        if (dyn_pd_en_i && idle) begin
          state_d      = ST_PD;
          sleep_mode_d = 1'b0;
        end else begin
          state_d = ST_ACTIVE;
        end
      end
      ST_PD:      if (wake)         state_d = ST_PD_EXIT;
      ST_PD_EXIT: if (last)         state_d = ST_ACTIVE;
      ST_SR:      if (!sleep_req_i) state_d = ST_SR_EXIT;
      ST_SR_EXIT: if (last)         state_d = ST_ACTIVE;
      default:                      state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_ACTIVE;
      sleep_mode_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      sleep_mode_q <= sleep_mode_d;
    end
  end

  assign load = ((state_q == ST_PD) && (state_d == ST_PD_EXIT)) ||
                ((state_q == ST_SR) && (state_d == ST_SR_EXIT));

  cke_pd_exit_sel #(.PD_W(PD_W), .SR_W(SR_W), .CNT_W(CNT_W)) i_exit_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .capture_i   ((state_d == ST_PD) && (state_q != ST_PD)),
    .bank_open_i (bank_open_i),
    .sel_sr_i    (state_q == ST_SR),
    .act_exit_i  (act_exit_i),
    .pre_exit_i  (pre_exit_i),
    .sr_exit_i   (sr_exit_i),
    .val_o       (exit_val)
  );

  cke_pd_exit_timer #(.CNT_W(CNT_W)) i_exit_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .val_i  (exit_val),
    .last_o (last)
  );

  assign cke_o   = !((state_q == ST_PD) || (state_q == ST_SR));
  assign ready_o = (state_q == ST_ACTIVE) || (state_q == ST_PD_ENTER);
  assign nop_o   = !ready_o;

  a_r10_nop_when_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> (nop_o && !ready_o));
  a_r10_ready_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cke_o && !nop_o));
  a_r5_rise_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> !ready_o);
  a_r2_fall_needs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> $past(!acc_pend_i));
  a_r7_sr_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_SR) && ($past(state_q) != ST_SR)) |-> $past(sr_en_i));
endmodule

// File: tb/test_cke_pd_ctrl.sv
module test_cke_pd_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dyn_en = 1'b0, sr_en = 1'b0, slp = 1'b0;
  logic       acc = 1'b0, rfp = 1'b0, bank = 1'b0;
  logic [3:0] act_x = 4'd6, pre_x = 4'd3;
  logic [7:0] sr_x = 8'd4;
  logic       cke, nop, rdy;
  int         n_chk = 0, n_fail = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  cke_pd_ctrl i_cke_pd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .dyn_pd_en_i(dyn_en), .sr_en_i(sr_en),
    .sleep_req_i(slp), .acc_pend_i(acc), .ref_pend_i(rfp), .bank_open_i(bank),
    .act_exit_i(act_x), .pre_exit_i(pre_x), .sr_exit_i(sr_x),
    .cke_o(cke), .nop_o(nop), .ready_o(rdy)
  );

  function automatic void cmp(logic [2:0] e, string tag);
    n_chk++;
    if ({cke, nop, rdy} !== e) begin
      n_fail++;
      $display("FAIL %s: {cke,nop,ready} got %b exp %b at %0t", tag, {cke, nop, rdy}, e, $time);
    end
  endfunction

  // monitor: one expectation per clock edge
  initial forever begin
    @(posedge clk); #2;
    if (exp_q.size() > 0) cmp(exp_q.pop_front(), tag_q.pop_front());
  end

  // apply at a falling edge, expect outputs after the following rising edge
  task automatic step(input logic a, r, d, s, b, input logic [2:0] e, input string tag);
    acc = a; rfp = r; dyn_en = d; slp = s; bank = b;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
  endtask

  localparam logic [2:0] ACT = 3'b101, LOW = 3'b010, EXT = 3'b110;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp(ACT, "R1 reset");

    // R6: disabled, idle
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, ACT, "R6 no entry");

    // precharge power-down, pre=3
    step(0, 0, 1, 0, 0, ACT, "R2 first idle edge");
    step(0, 0, 1, 0, 0, LOW, "R2 cke low");
    step(0, 0, 1, 0, 0, LOW, "R2 stays low");
    step(1, 0, 1, 0, 0, EXT, "R4 access wakes");
    step(1, 0, 1, 0, 0, EXT, "R5 pre exit");
    step(1, 0, 1, 0, 0, EXT, "R5 pre exit");
    step(1, 0, 1, 0, 0, ACT, "R5 pre ready");

    // active power-down, act=5, refresh wakes
    act_x = 4'd5;
    step(0, 0, 1, 0, 1, ACT, "R2 enter");
    step(0, 0, 1, 0, 1, LOW, "R2 low bank open");
    step(0, 1, 1, 0, 0, EXT, "R4 refresh wakes");
    for (int i = 0; i < 4; i++) step(0, 1, 1, 0, 0, EXT, "R5 act exit");
    step(0, 1, 1, 0, 0, ACT, "R5 act ready");

    // zero count, disable wakes
    pre_x = 4'd0;
    step(0, 0, 1, 0, 0, ACT, "R2 enter");
    step(0, 0, 1, 0, 0, LOW, "R2 low");
    step(0, 0, 0, 0, 0, EXT, "R4 disable wakes");
    step(0, 0, 0, 0, 0, ACT, "R5 zero count one cycle");

    // cancellation
    step(0, 0, 1, 0, 0, ACT, "R3 enter");
    step(1, 0, 1, 0, 0, ACT, "R3 access cancels");
    step(0, 0, 1, 0, 0, ACT, "R3 enter again");
    step(0, 0, 0, 0, 0, ACT, "R3 disable cancels");
    step(0, 0, 0, 0, 0, ACT, "R6 idle disabled");

    // self-refresh sleep, sr=4
    sr_en = 1'b1;
    step(1, 0, 0, 1, 0, ACT, "R7 access blocks sleep");
    step(0, 0, 0, 1, 0, LOW, "R7 self-refresh");
    step(1, 1, 1, 1, 0, LOW, "R7 work ignored");
    step(0, 0, 0, 0, 0, EXT, "R8 sr exit");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, EXT, "R8 sr exit");
    step(0, 0, 0, 0, 0, ACT, "R8 sr ready");

    // self-refresh zero count
    sr_x = 8'd0;
    step(0, 0, 0, 1, 0, LOW, "R7 self-refresh");
    step(0, 0, 0, 0, 0, EXT, "R8 zero sr count");
    step(0, 0, 0, 0, 0, ACT, "R8 zero sr ready");

    // sleep without self-refresh, pre=2
    sr_en = 1'b0; pre_x = 4'd2;
    step(0, 0, 0, 1, 0, LOW, "R9 sleep no refresh");
    step(0, 1, 0, 1, 0, LOW, "R9 refresh ignored");
    step(1, 0, 1, 1, 0, LOW, "R9 access ignored");
    step(1, 0, 0, 0, 0, EXT, "R9 pd exit");
    step(1, 0, 0, 0, 0, EXT, "R9 pd exit");
    step(1, 0, 0, 0, 0, ACT, "R9 ready");

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule